// File: doc/BRIEF.md
# Load Register Scoreboard

This block sits beside the issue stage of a pipelined core and remembers which registers are still waiting for data from memory. When a load instruction is accepted, its target register is marked pending. When the memory system hands back the data for that register, the mark is removed. Instructions that do not touch a pending register keep issuing while loads are in flight. An instruction that names a pending register as a source or as its destination is held back. The number of loads in flight is capped.

The issue stage offers one instruction per cycle on a valid/ready handshake. An instruction is accepted on a rising clock edge where `iss_valid` and `iss_ready` are both high. `iss_ready` is a combinational function of the offered fields, the pending state and the completion input in the same cycle. It does not depend on `iss_valid`. The issue stage must hold its fields steady while it waits. Completions use a valid-only input that is never back-pressured. Each completion names the register whose write has finished, and completions may come back in any order.

Top module: `load_scoreboard`

## Requirements
- R1: An accepted load (`iss_is_load`=1) sets bit `iss_dst` of `busy_o` on the clock edge that accepts it. Bit i of `busy_o` stands for register i.
- R2: A completion (`cmp_valid`=1) clears bit `cmp_idx` of `busy_o` on the next clock edge.
- R3: `iss_ready` is low while an enabled source index (`iss_src0_en`, `iss_src1_en`) or an enabled destination index (`iss_dst_en`, or any load) names a pending register. A field whose enable is low is not checked.
- R4: An instruction that touches no pending register is accepted while loads are outstanding.
- R5: No more than MAX_PEND (default 3) bits of `busy_o` are set at any time.
- R6: A load offered while MAX_PEND loads are pending sees `iss_ready` low until a completion frees an entry.
- R7: A completion that names a register that is not pending has no effect on `busy_o` or on the pending count.
- R8: A completion in the same cycle as an issue check is applied first. A register being completed does not stall that cycle, and its freed entry is counted toward the load limit.
- R9: Completions may arrive in any order, and each one clears only its own register.
- R10: When `rst_n` is low, all busy bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue stage offers an instruction |
| iss_ready | output | 1 | Offered instruction may issue this cycle |
| iss_is_load | input | 1 | Offered instruction is a load |
| iss_src0_en | input | 1 | First source index is in use |
| iss_src0 | input | 5 | First source register number |
| iss_src1_en | input | 1 | Second source index is in use |
| iss_src1 | input | 5 | Second source register number |
| iss_dst_en | input | 1 | Destination index is in use |
| iss_dst | input | 5 | Destination register number |
| cmp_valid | input | 1 | A load's data has been written |
| cmp_idx | input | 5 | Register number of that write |
| busy_o | output | 32 | Pending mark per register |

## Verification
A busy bit that is stuck high shows up as a permanent stall of any instruction naming that register. A lost busy bit shows up as an early grant of a dependent instruction. Either becomes visible in the first cycle an instruction offers that register, and also on `busy_o` one edge after the load or completion that caused it. A pending count that drifts away from the busy vector shows up as a fourth load granted, or a load refused while fewer than three are pending, on the next load offered after the drift.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_NREG_DEF    = 32;
  localparam int SB_MAXPEND_DEF = 3;

  typedef struct packed {
    logic src0;
    logic src1;
    logic dst;
  } sb_hit_t;
endpackage

// File: rtl/sb_onehot.sv
module sb_onehot #(
  parameter int N = 32,
  localparam int W = $clog2(N)
) (
  input  logic         en,
  input  logic [W-1:0] idx,
  output logic [N-1:0] vec
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign vec[i] = en && (idx == W'(i));
  end
endmodule

// File: rtl/sb_check.sv
module sb_check #(
  parameter int N = 32,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0]   pend,
  input  logic           s0_en,
  input  logic [W-1:0]   s0,
  input  logic           s1_en,
  input  logic [W-1:0]   s1,
  input  logic           d_en,
  input  logic [W-1:0]   d,
  output sb_pkg::sb_hit_t hit,
  output logic           hazard
);
  always_comb begin
    hit.src0 = s0_en && pend[s0];
    hit.src1 = s1_en && pend[s1];
    hit.dst  = d_en  && pend[d];
    hazard   = hit.src0 || hit.src1 || hit.dst;
  end
endmodule

// File: rtl/sb_state.sv
module sb_state #(
  parameter int N    = 32,
  parameter int MAXP = 3,
  localparam int CW  = $clog2(MAXP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  clr_vec,
  input  logic [N-1:0]  set_vec,
  output logic [N-1:0]  busy_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_eff
);
  logic clr_hit, set_hit;

  assign clr_hit = |(clr_vec & busy_q);
  assign set_hit = |set_vec;
  assign cnt_eff = cnt_q - CW'(clr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= (busy_q & ~clr_vec) | set_vec;
      cnt_q  <= cnt_eff + CW'(set_hit);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy_q) <= MAXP);  // R5
  AST_CNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) == $countones(busy_q));  // R5
endmodule

// File: rtl/load_scoreboard.sv
module load_scoreboard #(
  parameter int NREG    = sb_pkg::SB_NREG_DEF,
  parameter int MAXPEND = sb_pkg::SB_MAXPEND_DEF,
  localparam int IW     = $clog2(NREG),
  localparam int CW     = $clog2(MAXPEND + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  output logic            iss_ready,
  input  logic            iss_is_load,
  input  logic            iss_src0_en,
  input  logic [IW-1:0]   iss_src0,
  input  logic            iss_src1_en,
  input  logic [IW-1:0]   iss_src1,
  input  logic            iss_dst_en,
  input  logic [IW-1:0]   iss_dst,
  input  logic            cmp_valid,
  input  logic [IW-1:0]   cmp_idx,
  output logic [NREG-1:0] busy_o
);
  logic [NREG-1:0] clr_vec, set_vec, pend_eff;
  logic [CW-1:0]   cnt_q, cnt_eff;
  sb_pkg::sb_hit_t hit;
  logic            hazard, full, fire_ld;

  sb_onehot #(.N(NREG)) u_clr (.en(cmp_valid), .idx(cmp_idx), .vec(clr_vec));
  sb_onehot #(.N(NREG)) u_set (.en(fire_ld),   .idx(iss_dst), .vec(set_vec));

  // completion applied before the issue check
  assign pend_eff = busy_o & ~clr_vec;

  sb_check #(.N(NREG)) u_chk (
    .pend(pend_eff),
    .s0_en(iss_src0_en), .s0(iss_src0),
    .s1_en(iss_src1_en), .s1(iss_src1),
    .d_en(iss_dst_en || iss_is_load), .d(iss_dst),
    .hit(hit), .hazard(hazard)
  );

  assign full      = iss_is_load && (int'(cnt_eff) >= MAXPEND);
  assign iss_ready = !hazard && !full;
  assign fire_ld   = iss_valid && iss_ready && iss_is_load;

  sb_state #(.N(NREG), .MAXP(MAXPEND)) u_st (
    .clk(clk), .rst_n(rst_n),
    .clr_vec(clr_vec), .set_vec(set_vec),
    .busy_q(busy_o), .cnt_q(cnt_q), .cnt_eff(cnt_eff)
  );

  AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_is_load) |=> busy_o[$past(iss_dst)]);  // R1
  AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !(fire_ld && iss_dst == cmp_idx)) |=> !busy_o[$past(cmp_idx)]);  // R2
  AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |-> !(hit.src0 || hit.src1 || hit.dst));  // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_is_load && !cmp_valid && $countones(busy_o) >= MAXPEND) |-> !iss_ready);  // R6
endmodule

// File: tb/sim_load_scoreboard.sv
`timescale 1ns/1ps
module sim_load_scoreboard;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_ready, iss_is_load = 0;
  logic iss_src0_en = 0, iss_src1_en = 0, iss_dst_en = 0, cmp_valid = 0;
  logic [4:0] iss_src0 = 0, iss_src1 = 0, iss_dst = 0, cmp_idx = 0;
  logic [31:0] busy_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  load_scoreboard u0 (.*);

  typedef struct packed {
    logic cv; logic [4:0] ci;
    logic v; logic ld;
    logic e0; logic [4:0] s0;
    logic e1; logic [4:0] s1;
    logic ed; logic [4:0] d;
    logic rdy; logic [31:0] bz;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{0,0, 1,1, 0,0, 0,0, 1,4, 1, 32'h10},   // R1 load r4
    '{0,0, 1,1, 0,0, 0,0, 1,5, 1, 32'h30},   // R1 load r5
    '{0,0, 1,0, 1,1, 1,2, 1,3, 1, 32'h30},   // R4 independent op
    '{0,0, 1,0, 1,4, 0,0, 0,0, 0, 32'h30},   // R3 src0 pending
    '{0,0, 1,0, 0,0, 1,5, 0,0, 0, 32'h30},   // R3 src1 pending
    '{0,0, 1,0, 0,0, 0,0, 1,4, 0, 32'h30},   // R3 dst pending
    '{0,0, 1,1, 0,0, 0,0, 1,6, 1, 32'h70},   // R1 third load
    '{0,0, 1,1, 0,0, 0,0, 1,7, 0, 32'h70},   // R6 fourth load held
    '{1,5, 1,1, 0,0, 0,0, 1,7, 1, 32'hD0},   // R8 R9 r5 done first, load r7
    '{1,4, 1,0, 1,4, 0,0, 0,0, 1, 32'hC0},   // R8 read r4 as it completes
    '{1,9, 1,1, 0,0, 0,0, 1,8, 1, 32'h1C0},  // R7 r9 idle ignored; 2 pending -> load r8
    '{0,0, 1,0, 0,6, 0,0, 1,9, 1, 32'h1C0},  // R3 disabled src not checked
    '{1,7, 0,0, 0,0, 0,0, 0,0, 1, 32'h140},  // R2 clear r7
    '{1,6, 0,0, 0,0, 0,0, 0,0, 1, 32'h100}   // R2 R9 clear r6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    cmp_valid = t.cv; cmp_idx = t.ci;
    iss_valid = t.v; iss_is_load = t.ld;
    iss_src0_en = t.e0; iss_src0 = t.s0;
    iss_src1_en = t.e1; iss_src1 = t.s1;
    iss_dst_en = t.ed; iss_dst = t.d;
  endtask

  initial begin
    #4000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R10 reset busy", busy_o, 32'h0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #1 chk($sformatf("R3/R6 ready step %0d", i), {31'b0, iss_ready}, {31'b0, TBL[i].rdy});
      @(posedge clk); #1;
      chk($sformatf("R1/R2 busy step %0d", i), busy_o, TBL[i].bz);
    end
    // R5 fill to limit with r8 pending: two more loads, third refused
    @(negedge clk); drive('{0,0, 1,1, 0,0, 0,0, 1,10, 1, 0});
    @(negedge clk); drive('{0,0, 1,1, 0,0, 0,0, 1,11, 1, 0});
    @(negedge clk); drive('{0,0, 1,1, 0,0, 0,0, 1,12, 1, 0});
    #1 chk("R5 limit ready", {31'b0, iss_ready}, 32'h0);
    @(posedge clk); #1 chk("R5 limit busy", busy_o, 32'hD00);
    // R10 reset in mid-run
    @(negedge clk); drive('0); rst_n = 0;
    #1 chk("R10 async clear", busy_o, 32'h0);
    @(negedge clk); rst_n = 1;
    drive('{0,0, 1,0, 1,10, 1,11, 1,12, 1, 0});
    #1 chk("R10 ready after reset", {31'b0, iss_ready}, 32'h1);
    @(negedge clk); drive('0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule